// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Pointer Synchronizers

This block carries data words from a write clock domain to an unrelated read clock domain. Each domain has its own request input, its own full and empty flags and its own occupancy count. Write and read positions cross the boundary as gray-coded pointers. Each pointer is one bit wider than the address, and the extra bit tells a full buffer from an empty one. Each crossing passes through a chain of flip-flops in the receiving clock. The chain length is a parameter that is set on its own for each direction: `W2R_STAGES` for writer to reader and `R2W_STAGES` for reader to writer.

The latencies of flags and counts are exact. In the domain that made a request, the flags move on the next edge and the count one edge after that. In the far domain, the flags move a fixed number of source edges plus as many destination edges as the synchronizer is long, and the count one destination edge later.

The read port has two modes, chosen by `SHOW_AHEAD`:
- **Normal (0):** `rd_data` loads the consumed word on the edge that accepts a read, and holds its value otherwise.
- **Show-ahead (1):** `rd_data` always presents the oldest stored word.

Each domain keeps a fill-level state register with three states:
- `LVL_EMPTY`, `LVL_PART` and `LVL_FULL`.
- On every local edge the next state is chosen from the occupancy after that edge. An occupancy of zero gives `LVL_EMPTY`, an occupancy of the depth gives `LVL_FULL`, and any other value gives `LVL_PART`.
- Every transition between the three states can occur: EMPTY to PART, PART to FULL, FULL to PART, PART to EMPTY, and directly between EMPTY and FULL when the depth is reached or left in one step.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, both domains show empty=1, full=0 and count=0.
- R2: A write accepted at a `wr_clk` edge updates `wr_empty` and `wr_full` at that same edge (one write clock of latency). `wr_full` rises on the edge that accepts the DEPTH-th word.
- R3: `wr_count` reflects an accepted write one `wr_clk` edge after the flags do (two write clocks).
- R4: A write reaches `rd_empty` and `rd_full` on the W2R_STAGES-th `rd_clk` edge after the second `wr_clk` edge. It reaches `rd_count` one `rd_clk` edge later.
- R5: A read accepted at a `rd_clk` edge updates `rd_empty` and `rd_full` at that edge, and `rd_count` on the following `rd_clk` edge.
- R6: A read reaches `wr_empty` and `wr_full` on the R2W_STAGES-th `wr_clk` edge after the read edge. It reaches `wr_count` one `wr_clk` edge later.
- R7: With SHOW_AHEAD=0, `rd_data` takes the consumed word on the edge that accepts the read, and keeps its value on every other edge.
- R8: With SHOW_AHEAD=1, `rd_data` presents the oldest stored word:
  - it advances to the next word on the edge that accepts a read;
  - a word written into an empty buffer appears on the first `rd_clk` edge after the write edge.
- R9: A write request while `wr_full` is 1 stores nothing and moves no pointer.
- R10: A read request while `rd_empty` is 1 consumes nothing and moves no pointer.
- R11: Words leave in the order they were accepted, with none lost or repeated.
- R12: Each crossing gray pointer changes at most one bit per edge of its own clock.
- R13: In each domain, full and empty are never 1 together, and the count never exceeds DEPTH = 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Write-side full flag |
| wr_empty | output | 1 | Write-side empty flag |
| wr_count | output | ADDR_W+1 | Write-side occupancy |
| rd_clk | input | 1 | Read domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word (registered) |
| rd_full | output | 1 | Read-side full flag |
| rd_empty | output | 1 | Read-side empty flag |
| rd_count | output | ADDR_W+1 | Read-side occupancy |

## Verification
A wrong state in this block shows at the ports in the following ways:
- **Wrong fill-level state or pointer:** a flag that is off from the edge where the latency rules say it must change. The directed tests count the edges of both clocks to catch a flag that arrives one edge early or late.
- **Overrun of the full boundary or underrun of the empty boundary:** a word that is dropped or repeated. This becomes visible on `rd_data` at the next consumption that reaches that slot.
- **Wrong pointer difference:** a count that does not settle to the number of words the bench knows are stored, once both domains go quiet.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Fill level of one domain's view of the buffer
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'b00,
        LVL_PART  = 2'b01,
        LVL_FULL  = 2'b10
    } fill_lvl_e;

endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a gray-coded pointer.
// 'early' is the next-to-last stage; 'settled' is the last one. STAGES >= 2.
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] early,
    output logic [W-1:0] settled
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign early   = chain[STAGES-2];
    assign settled = chain[STAGES-1];

endmodule

// File: rtl/dcf_side.sv
// One clock domain of the FIFO: local pointer, synchronized far pointer,
// fill-level state register, flags, occupancy count and outgoing gray pointer.
module dcf_side
    import dcf_pkg::*;
#(
    parameter int AW        = 4,
    parameter int STAGES    = 2,
    parameter bit IS_WR     = 1'b1,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW:0]   far_gray,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   level,
    output logic [AW:0]   near_gray,
    output logic          accept,
    output logic [AW-1:0] mem_addr
);

    localparam int          PW       = AW + 1;
    localparam logic [AW:0] OCC_FULL = {1'b1, {AW{1'b0}}};

    function automatic logic [AW:0] b2g(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [AW:0] ptr, ptr_nx;
    logic [AW:0] far_early, far_settled;
    logic [AW:0] far_early_b, far_settled_b;
    logic [AW:0] occ_nx;
    fill_lvl_e   lvl_q, lvl_d;

    dcf_sync #(.W(PW), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (far_gray),
        .early   (far_early),
        .settled (far_settled)
    );

    assign far_early_b   = g2b(far_early);
    assign far_settled_b = g2b(far_settled);

    // Writer is blocked by full, reader by empty
    assign accept = req && (IS_WR ? !full : !empty);
    assign ptr_nx = ptr + PW'(accept);
    assign occ_nx = IS_WR ? (ptr_nx - far_early_b) : (far_early_b - ptr_nx);

    // Next fill level from occupancy after this edge
    always_comb begin
        if (occ_nx == '0)
            lvl_d = LVL_EMPTY;
        else if (occ_nx == OCC_FULL)
            lvl_d = LVL_FULL;
        else
            lvl_d = LVL_PART;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_EMPTY;
        else        lvl_q <= lvl_d;
    end

    // Flag outputs decoded from the state
    always_comb begin
        unique case (lvl_q)
            LVL_EMPTY: begin full = 1'b0; empty = 1'b1; end
            LVL_PART:  begin full = 1'b0; empty = 1'b0; end
            LVL_FULL:  begin full = 1'b1; empty = 1'b0; end
            default:   begin full = 1'b0; empty = 1'b0; end
        endcase
    end

    // Pointer and occupancy count (count lags the flags by one edge)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            level <= '0;
        end else begin
            ptr   <= ptr_nx;
            level <= IS_WR ? (ptr - far_settled_b) : (far_settled_b - ptr);
        end
    end

    // Outgoing gray pointer: one edge behind on the write side,
    // on the accepting edge on the read side
    generate
        if (IS_WR) begin : g_gray_lag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) near_gray <= '0;
                else        near_gray <= b2g(ptr);
            end
        end else begin : g_gray_lead
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) near_gray <= '0;
                else        near_gray <= b2g(ptr_nx);
            end
        end
    endgenerate

    generate
        if (LOOKAHEAD) begin : g_addr_next
            assign mem_addr = ptr_nx[AW-1:0];
        end else begin : g_addr_cur
            assign mem_addr = ptr[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/dcf_ram.sv
// Storage array: written in the write domain, registered read in the read domain.
module dcf_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int W2R_STAGES = 2,
    parameter int R2W_STAGES = 2,
    parameter bit SHOW_AHEAD = 1'b1
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_empty,
    output logic [ADDR_W:0]   wr_count,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_full,
    output logic              rd_empty,
    output logic [ADDR_W:0]   rd_count
);

    logic [ADDR_W:0]   wr_gray, rd_gray;
    logic              wr_acc, rd_acc;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              ram_rd_en;

    dcf_side #(
        .AW(ADDR_W), .STAGES(R2W_STAGES), .IS_WR(1'b1), .LOOKAHEAD(1'b0)
    ) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .req       (wr_en),
        .far_gray  (rd_gray),
        .full      (wr_full),
        .empty     (wr_empty),
        .level     (wr_count),
        .near_gray (wr_gray),
        .accept    (wr_acc),
        .mem_addr  (wr_addr)
    );

    dcf_side #(
        .AW(ADDR_W), .STAGES(W2R_STAGES), .IS_WR(1'b0), .LOOKAHEAD(SHOW_AHEAD)
    ) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .req       (rd_en),
        .far_gray  (wr_gray),
        .full      (rd_full),
        .empty     (rd_empty),
        .level     (rd_count),
        .near_gray (rd_gray),
        .accept    (rd_acc),
        .mem_addr  (rd_addr)
    );

    // Show-ahead refreshes the output register every edge from the next head;
    // normal mode loads it only when a read is accepted
    assign ram_rd_en = (SHOW_AHEAD != 1'b0) || rd_acc;

    dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_acc),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (ram_rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int AW = 4
) (
    input logic          rst_n,
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          wr_empty,
    input logic          rd_full,
    input logic          rd_empty,
    input logic [AW:0]   wr_count,
    input logic [AW:0]   rd_count,
    input logic [AW:0]   wr_gray,
    input logic [AW:0]   rd_gray
);

    localparam logic [AW:0] OCC_FULL = {1'b1, {AW{1'b0}}};

    // R2
    wr_accept_clears_empty_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !wr_full) |=> !wr_empty);

    // R5
    rd_accept_clears_full_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && !rd_empty) |=> !rd_full);

    // R9
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |-> ##2 $stable(wr_gray));

    // R10
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty |=> $stable(rd_gray));

    // R12
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R12
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    // R13
    wr_flags_excl_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(wr_full && wr_empty) && (wr_count <= OCC_FULL));

    // R13
    rd_flags_excl_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(rd_full && rd_empty) && (rd_count <= OCC_FULL));

endmodule

bind dual_clock_fifo dcf_chk #(.AW(ADDR_W)) u_dcf_chk (
    .rst_n    (rst_n),
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_full  (wr_full),
    .wr_empty (wr_empty),
    .rd_full  (rd_full),
    .rd_empty (rd_empty),
    .wr_count (wr_count),
    .rd_count (rd_count),
    .wr_gray  (wr_gray),
    .rd_gray  (rd_gray)
);

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/10ps
module tb_dual_clock_fifo;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int N_W2R = 3;
    localparam int N_R2W = 2;

    logic          rst_n;
    logic          wr_clk;
    logic          rd_clk;
    logic          wr_en;
    logic          rd_en;
    logic [DW-1:0] wr_data;

    logic          wr_full, wr_empty, rd_full, rd_empty;
    logic [AW:0]   wr_count, rd_count;
    logic [DW-1:0] q_sa;
    logic          n_wr_full, n_wr_empty, n_rd_full, n_rd_empty;
    logic [AW:0]   n_wr_count, n_rd_count;
    logic [DW-1:0] q_nr;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [DW-1:0] sb [$];

    dual_clock_fifo #(
        .DATA_W(DW), .ADDR_W(AW), .W2R_STAGES(N_W2R), .R2W_STAGES(N_R2W), .SHOW_AHEAD(1'b1)
    ) dut (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_empty(wr_empty), .wr_count(wr_count),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(q_sa),
        .rd_full(rd_full), .rd_empty(rd_empty), .rd_count(rd_count)
    );

    dual_clock_fifo #(
        .DATA_W(DW), .ADDR_W(AW), .W2R_STAGES(N_W2R), .R2W_STAGES(N_R2W), .SHOW_AHEAD(1'b0)
    ) dut_nrm (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(n_wr_full), .wr_empty(n_wr_empty), .wr_count(n_wr_count),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(q_nr),
        .rd_full(n_rd_full), .rd_empty(n_rd_empty), .rd_count(n_rd_count)
    );

    // 250 MHz write clock; read clock of 7 ns with an offset so edges never coincide
    initial begin
        wr_clk = 1'b0;
        forever #2 wr_clk = ~wr_clk;
    end

    initial begin
        rd_clk = 1'b0;
        #0.7;
        forever begin
            rd_clk = 1'b1; #3.5;
            rd_clk = 1'b0; #3.5;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected width-limited occupancy of a full buffer, as a bench value
    function automatic int full_occ();
        return DEPTH;
    endfunction

    task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   = en;
        wr_data = d;
        if (en && !wr_full) sb.push_back(d);
        @(posedge wr_clk);
        #0.1;
        check("R13", "wr_count bound", (wr_count <= full_occ()), 1);
    endtask

    task automatic rd_cycle(input bit en);
        bit            take;
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        rd_en = en;
        take  = en && !rd_empty;
        exp   = '0;
        if (take) begin
            if (sb.size() == 0) begin
                check("R11", "read with no stored word", 1, 0);
                take = 1'b0;
            end else begin
                exp = sb.pop_front();
                check("R8", "show-ahead head word", q_sa, exp);
            end
        end
        @(posedge rd_clk);
        #0.1;
        if (take) check("R7", "normal consumed word", q_nr, exp);
        check("R13", "rd_count bound", (rd_count <= full_occ()), 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_data = '0;

        // R1: reset state
        repeat (3) @(posedge wr_clk);
        #0.1;
        check("R1", "wr_empty in reset", wr_empty, 1);
        check("R1", "rd_empty in reset", rd_empty, 1);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (2) @(posedge wr_clk);
        #0.1;
        check("R1", "wr_empty", wr_empty, 1);
        check("R1", "wr_full", wr_full, 0);
        check("R1", "wr_count", wr_count, 0);
        repeat (2) @(posedge rd_clk);
        #0.1;
        check("R1", "rd_empty", rd_empty, 1);
        check("R1", "rd_full", rd_full, 0);
        check("R1", "rd_count", rd_count, 0);

        // Single write: local and cross-domain latencies
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = 8'hA5;
        @(posedge wr_clk);
        #0.1;
        wr_en = 1'b0;
        check("R2", "wr_empty one edge after write", wr_empty, 0);
        check("R3", "wr_count not yet updated", wr_count, 0);
        fork
            begin
                @(posedge rd_clk);
                #0.1;
                check("R8", "written word on first rd edge", q_sa, 8'hA5);
            end
            begin
                @(posedge wr_clk);
                #0.1;
                check("R3", "wr_count two edges after write", wr_count, 1);
                for (int i = 1; i <= N_W2R + 1; i++) begin
                    @(posedge rd_clk);
                    #0.1;
                    if (i < N_W2R) check("R4", "rd_empty before sync depth", rd_empty, 1);
                    if (i == N_W2R) begin
                        check("R4", "rd_empty at sync depth", rd_empty, 0);
                        check("R4", "rd_count before sync depth+1", rd_count, 0);
                    end
                    if (i == N_W2R + 1) check("R4", "rd_count at sync depth+1", rd_count, 1);
                end
            end
        join
        check("R7", "normal rd_data held without read", q_nr, 0);

        // Single read: local and cross-domain latencies
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #0.1;
        rd_en = 1'b0;
        check("R5", "rd_empty one edge after read", rd_empty, 1);
        check("R5", "rd_count not yet updated", rd_count, 1);
        check("R7", "normal word after read", q_nr, 8'hA5);
        fork
            begin
                @(posedge rd_clk);
                #0.1;
                check("R5", "rd_count two edges after read", rd_count, 0);
            end
            begin
                for (int i = 1; i <= N_R2W + 1; i++) begin
                    @(posedge wr_clk);
                    #0.1;
                    if (i < N_R2W) check("R6", "wr_empty before sync depth", wr_empty, 0);
                    if (i == N_R2W) begin
                        check("R6", "wr_empty at sync depth", wr_empty, 1);
                        check("R6", "wr_count before sync depth+1", wr_count, 1);
                    end
                    if (i == N_R2W + 1) check("R6", "wr_count at sync depth+1", wr_count, 0);
                end
            end
        join

        // R10: reads while empty are ignored
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (3) @(posedge rd_clk);
        #0.1;
        rd_en = 1'b0;
        check("R10", "rd_empty stays set", rd_empty, 1);
        check("R10", "rd_count stays zero", rd_count, 0);
        check("R10", "normal rd_data unchanged", q_nr, 8'hA5);
        repeat (N_R2W + 3) @(posedge wr_clk);
        #0.1;
        check("R10", "wr_count stays zero", wr_count, 0);

        // R9: fill past the boundary; extra writes dropped
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_cycle(1'b1, 8'(8'h10 + i));
            if (i == DEPTH - 2) check("R2", "wr_full one below depth", wr_full, 0);
            if (i == DEPTH - 1) check("R2", "wr_full at depth", wr_full, 1);
        end
        wr_cycle(1'b0, 8'h00);
        wr_cycle(1'b0, 8'h00);
        check("R9", "wr_count capped at depth", wr_count, DEPTH);
        repeat (N_W2R + 4) @(posedge rd_clk);
        #0.1;
        check("R4", "rd_full after crossing", rd_full, 1);
        check("R4", "rd_count after crossing", rd_count, DEPTH);

        // One read from full: local drop and cross-domain release
        @(negedge rd_clk);
        check("R8", "head word while full", q_sa, 8'h10);
        rd_en = 1'b1;
        void'(sb.pop_front());
        @(posedge rd_clk);
        #0.1;
        rd_en = 1'b0;
        check("R5", "rd_full one edge after read", rd_full, 0);
        check("R7", "normal word from full", q_nr, 8'h10);
        check("R8", "show-ahead advanced", q_sa, 8'h11);
        for (int i = 1; i <= N_R2W + 1; i++) begin
            @(posedge wr_clk);
            #0.1;
            if (i < N_R2W) check("R6", "wr_full before sync depth", wr_full, 1);
            if (i == N_R2W) begin
                check("R6", "wr_full at sync depth", wr_full, 0);
                check("R6", "wr_count before sync depth+1", wr_count, DEPTH);
            end
            if (i == N_R2W + 1) check("R6", "wr_count at sync depth+1", wr_count, DEPTH - 1);
        end

        // R11: drain in order
        repeat (DEPTH + N_W2R + 6) rd_cycle(1'b1);
        rd_cycle(1'b0);
        check("R11", "words left after drain", sb.size(), 0);
        check("R10", "rd_empty after overdrain", rd_empty, 1);

        // Random traffic in both domains
        fork
            begin
                repeat (900) wr_cycle(($urandom % 100) < 50, 8'($urandom));
                wr_cycle(1'b0, 8'h00);
            end
            begin
                repeat (600) rd_cycle(($urandom % 100) < 45);
            end
        join
        repeat (DEPTH + N_W2R + 10) rd_cycle(1'b1);
        rd_cycle(1'b0);
        repeat (N_R2W + 4) wr_cycle(1'b0, 8'h00);
        check("R11", "words left after random", sb.size(), 0);
        check("R13", "wr_empty settles", wr_empty, 1);
        check("R13", "wr_count settles", wr_count, 0);
        check("R13", "rd_count settles", rd_count, 0);
        check("R13", "rd_full settles", rd_full, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule